// File: doc/BRIEF.md
# Configurable SPI Master Channel

A single synchronous serial master channel that shifts a frame out on its data output and, in the same frame, samples one in on its data input. Three words set it up: a mode word (operating clock source and interrupt source), an operation word (transmit and receive enables, clock phase, clock polarity, bit order and frame length) and a shared data register. While the channel is stopped, the upper seven bits of the data register hold the serial clock divider. While it runs, the low byte is the transmit buffer on write and the last received frame on read.

The operating clock is a clock enable taken from one of two prescaler enable inputs. Software stops the channel with `run_en` low, programs the configuration and the divider, raises `run_en`, and then writes transmit bytes. The channel pulses `irq` either when a frame completes or when the transmit buffer has been handed to the shifter. The second choice lets a new byte be queued while the current one is still shifting, so frames follow with no gap.

Top module: `spi_master_chan`

## Requirements
- R1: After reset, all three words read as zero and `sck`, `sdo` and `irq` are low. Register addresses are 0 = mode word, 1 = operation word, 2 = data register.
- R2: Mode bit 15 picks the operating clock enable: 0 uses `pre_en0`, 1 uses `pre_en1`. The other input has no effect on timing.
- R3: Each `sck` half period lasts (divider + 1) operating clock enables. Between frames, and after the last edge of a frame, `sck` rests at operation bit 12 (polarity).
- R4: Operation bit 13 (phase) = 0: the first bit is on `sdo` before the first edge, `sdi` is sampled on leading edges and `sdo` changes on trailing edges. Phase = 1: `sdo` changes on leading edges and `sdi` is sampled on trailing edges.
- R5: Operation bit 7 = 0 sends and receives the most significant bit first. 1 sends and receives the least significant bit first.
- R6: Operation bits 3:0 hold a length code c. A frame has c+1 bits for c below 7 and 8 bits otherwise, which is 2×bits `sck` edges. Only the low-order bits of the transmit byte are sent. The received value is right-aligned with zeros above it.
- R7: A frame starts only while `run_en` is high and both operation bit 15 (transmit enable) and bit 14 (receive enable) are set.
- R8: Stopped: the data register reads {divider, nine zeros}, and a write loads the divider from bits 15:9. Running: writes to bits 15:9 are ignored, a write loads the low byte into the transmit buffer and starts a frame when the shifter is idle, and a read returns the last received frame in the low byte with zeros above it.
- R9: Writes to the mode and operation words are ignored while `run_en` is high.
- R10: Mode bit 0 = 0 gives a one-cycle `irq` pulse after the last edge of each frame, with the received byte then readable. Mode bit 0 = 1 gives the pulse when the buffered byte moves into the shifter, before that frame's first edge, so a byte written after the pulse follows with no gap.
- R11: Between frames `sdo` holds the last bit it sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel running when high, stopped when low |
| pre_en0 | input | 1 | First prescaler clock enable |
| pre_en1 | input | 1 | Second prescaler clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 mode, 1 operation, 2 data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected address |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume `run_en` stays high for the whole of a frame, so that the length code and polarity seen by the frame engine do not change between its start and its last edge. The design keeps the configuration words fixed while running, and the stimulus drops `run_en` only after every frame has finished. The bench acts as a slave: it reacts to `sck` edges half a clock away from the sampling edge. It computes the expected bit order, frame value and edge spacing from each vector's settings. A free-running pulse on the unselected prescaler input shows that the source selection works.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_OP   = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // mode word fields
    localparam int MODE_CKSEL_B = 15;
    localparam int MODE_IRQ_B   = 0;

    // operation word fields
    localparam int OP_TXE_B = 15;
    localparam int OP_RXE_B = 14;
    localparam int OP_PHA_B = 13;
    localparam int OP_POL_B = 12;
    localparam int OP_LSB_B = 7;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en0,
    input  logic             en1,
    input  logic             sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } baud_t;

    baud_t q, d;
    logic  en_sel;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        en_sel = sel ? en1 : en0;
        if (clr) begin
            d.cnt = '0;
        end else if (en_sel) begin
            if (q.cnt == div) begin
                d.cnt  = '0;
                d.tick = 1'b1;
            end else begin
                d.cnt = q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R3: the counter never passes the divider while counting
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && $past(!clr)) |-> (q.cnt <= div));
endmodule

// File: rtl/spi_frame_eng.sv
module spi_frame_eng #(
    parameter int DATA_W = 8,
    localparam int NB_W   = $clog2(DATA_W + 1),
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int EDGE_W = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              pol,
    input  logic              pha,
    input  logic              lsb_first,
    input  logic [NB_W-1:0]   nbits,
    input  logic              tick,
    input  logic              sdi,
    output logic              busy,
    output logic              sck,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              sdo;
        logic              done;
        logic [EDGE_W-1:0] edge_n;
        logic [NB_W-1:0]   out_t;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } eng_t;

    eng_t q, d;
    logic [EDGE_W-1:0] last_edge;
    logic              leading;
    logic              smp_edge;

    // bit of the word that goes out in time slot t
    function automatic logic pick(logic [DATA_W-1:0] w, logic [NB_W-1:0] t,
                                  logic [NB_W-1:0] n, logic lsb);
        logic [NB_W-1:0] i;
        i = lsb ? t : (n - NB_W'(1) - t);
        return w[i[SEL_W-1:0]];
    endfunction

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        last_edge = EDGE_W'({nbits, 1'b0} - (NB_W+1)'(1));
        leading   = ~q.edge_n[0];
        smp_edge  = pha ? ~leading : leading;
        if (abort) begin
            d.busy = 1'b0;
            d.sck  = pol;
        end else if (start && !q.busy) begin
            d.busy   = 1'b1;
            d.edge_n = '0;
            d.tx     = tx_data;
            d.rx     = '0;
            d.sck    = pol;
            if (!pha) begin
                d.sdo   = pick(tx_data, '0, nbits, lsb_first);
                d.out_t = NB_W'(1);
            end else begin
                d.out_t = '0;
            end
        end else if (q.busy && tick) begin
            d.sck = ~q.sck;
            if (smp_edge) begin
                if (lsb_first) d.rx[q.edge_n[EDGE_W-1:1]] = sdi;
                else           d.rx = {q.rx[DATA_W-2:0], sdi};
            end else if (q.out_t < nbits) begin
                d.sdo   = pick(q.tx, q.out_t, nbits, lsb_first);
                d.out_t = q.out_t + NB_W'(1);
            end
            if (q.edge_n == last_edge) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.edge_n = q.edge_n + EDGE_W'(1);
            end
        end else if (!q.busy) begin
            d.sck = pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sck     = q.sck;
    assign sdo     = q.sdo;
    assign done    = q.done;
    assign rx_data = q.rx;

    // R3: after its edges a frame leaves the clock at its resting level
    p_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.sck == pol));
    // R6: the edge counter stays inside twice the frame length
    p_edge_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> ({1'b0, q.edge_n} < {nbits, 1'b0}));
    // R11: the data output does not move while no frame runs
    p_sdo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !$past(q.busy)) |-> $stable(q.sdo));
endmodule

// File: rtl/spi_master_chan.sv
module spi_master_chan
    import spi_chan_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DIV_W  = 7,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4,
    localparam int NB_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pre_en0,
    input  logic             pre_en1,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sdi,
    output logic             sck,
    output logic             sdo,
    output logic             irq
);
    typedef struct packed {
        logic [REG_W-1:0]  mode;
        logic [REG_W-1:0]  op;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] txbuf;
        logic              txfull;
        logic [DATA_W-1:0] rxd;
        logic              irq;
    } chan_t;

    chan_t q, d;

    logic              eng_busy, eng_done, tick, start, chan_ok;
    logic [DATA_W-1:0] eng_rx;
    logic [LEN_W-1:0]  len_code;
    logic [NB_W-1:0]   nbits;

    assign chan_ok  = run_en && q.op[OP_TXE_B] && q.op[OP_RXE_B];
    assign start    = chan_ok && !eng_busy && q.txfull;
    assign len_code = q.op[LEN_W-1:0];
    assign nbits    = (len_code >= LEN_W'(DATA_W - 1)) ? NB_W'(DATA_W)
                                                       : NB_W'(len_code) + NB_W'(1);

    always_comb begin
        d     = q;
        d.irq = q.mode[MODE_IRQ_B] ? start : eng_done;
        if (start)    d.txfull = 1'b0;
        if (!run_en)  d.txfull = 1'b0;
        if (eng_done) d.rxd    = eng_rx;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_MODE: if (!run_en) d.mode = reg_wdata;
                ADDR_OP:   if (!run_en) d.op   = reg_wdata;
                ADDR_DATA: begin
                    if (run_en) begin
                        d.txbuf  = reg_wdata[DATA_W-1:0];
                        d.txfull = 1'b1;
                    end else begin
                        d.div = reg_wdata[REG_W-1:REG_W-DIV_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_MODE: reg_rdata = q.mode;
            ADDR_OP:   reg_rdata = q.op;
            ADDR_DATA: reg_rdata = run_en ? {{(REG_W-DATA_W){1'b0}}, q.rxd}
                                          : {q.div, {(REG_W-DIV_W){1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end

    spi_baud_gen #(.DIV_W(DIV_W)) i_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!eng_busy),
        .en0   (pre_en0),
        .en1   (pre_en1),
        .sel   (q.mode[MODE_CKSEL_B]),
        .div   (q.div),
        .tick  (tick)
    );

    spi_frame_eng #(.DATA_W(DATA_W)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!run_en),
        .start     (start),
        .tx_data   (q.txbuf),
        .pol       (q.op[OP_POL_B]),
        .pha       (q.op[OP_PHA_B]),
        .lsb_first (q.op[OP_LSB_B]),
        .nbits     (nbits),
        .tick      (tick),
        .sdi       (sdi),
        .busy      (eng_busy),
        .sck       (sck),
        .sdo       (sdo),
        .done      (eng_done),
        .rx_data   (eng_rx)
    );

    assign irq = q.irq;

    // R8: the divider cannot change during a cycle that followed running
    p_div_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> $stable(q.div));
    // R9: configuration words keep their value while running
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> ($stable(q.mode) && $stable(q.op)));
    // R7: a frame only begins with both enables set
    p_start_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> (q.op[OP_TXE_B] && q.op[OP_RXE_B] && run_en));
    // R10: the interrupt is a single-cycle pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/test_spi_master_chan.sv
module test_spi_master_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        pre_en0 = 1'b1;
    logic        pre_en1 = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        sdi = 1'b0;
    logic        sck, sdo, irq;

    int total = 0;
    int bad = 0;

    // monitor state (acts on falling clock edges only)
    int          mon_edges = 0;
    int          mon_irqs = 0;
    logic [15:0] mon_cap = '0;
    logic        mon_prev = 1'b0;

    typedef struct packed {
        logic       pol;
        logic       pha;
        logic       lsb;
        logic [3:0] code;
        logic [6:0] div;
        logic       sel;
        logic       src;
        logic [7:0] tx;
        logic [7:0] srx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 4'd7,  7'd0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        '{1'b0, 1'b1, 1'b0, 4'd7,  7'd1, 1'b0, 1'b0, 8'h96, 8'hC3},
        '{1'b1, 1'b0, 1'b1, 4'd7,  7'd2, 1'b0, 1'b1, 8'h5A, 8'h81},
        '{1'b1, 1'b1, 1'b1, 4'd7,  7'd0, 1'b0, 1'b0, 8'h0F, 8'hF0},
        '{1'b0, 1'b0, 1'b1, 4'd3,  7'd0, 1'b1, 1'b0, 8'hFB, 8'h0D},
        '{1'b1, 1'b1, 1'b0, 4'd4,  7'd3, 1'b1, 1'b1, 8'hE6, 8'hFF},
        '{1'b0, 1'b1, 1'b1, 4'd12, 7'd1, 1'b0, 1'b0, 8'h71, 8'h2E},
        '{1'b1, 1'b0, 1'b0, 4'd0,  7'd0, 1'b0, 1'b1, 8'h01, 8'h01}
    };

    always #4 clk = ~clk;

    spi_master_chan i_spi_master_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .pre_en0   (pre_en0),
        .pre_en1   (pre_en1),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sdi       (sdi),
        .sck       (sck),
        .sdo       (sdo),
        .irq       (irq)
    );

    initial begin
        int pc;
        pc = 0;
        forever begin
            @(negedge clk);
            pc++;
            pre_en1 = (pc % 3 == 0);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (sck != mon_prev) begin
                mon_edges++;
                if (sck) mon_cap = {mon_cap[14:0], sdo};
            end
            mon_prev = sck;
            if (irq) mon_irqs++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic int frame_len(input logic [3:0] code);
        return (code >= 4'd7) ? 8 : int'(code) + 1;
    endfunction

    function automatic logic slot_bit(input logic [7:0] w, input int t, input int n, input logic lsb);
        return lsb ? w[t] : w[n-1-t];
    endfunction

    task automatic run_vec(input vec_t v);
        int n, edges, capn, st, irqs, irq_edge, cyc, last, post, ivbad, expint;
        logic [7:0] mask, capv;
        logic [15:0] r;
        logic prev, lead, hold;
        n = frame_len(v.code);
        mask = 8'hFF >> (8 - n);
        expint = (int'(v.div) + 1) * (v.sel ? 3 : 1);
        @(negedge clk); run_en = 1'b0;
        wr(2'd0, {v.sel, 14'b0, v.src});
        wr(2'd1, {2'b11, v.pha, v.pol, 4'b0, v.lsb, 3'b0, v.code});
        wr(2'd2, {v.div, 9'b0});
        rd(2'd2, r);
        chk(r == {v.div, 9'b0}, "R8 stopped divider readback", r, {v.div, 9'b0});
        @(negedge clk); run_en = 1'b1;
        st = 0;
        if (!v.pha) begin sdi = slot_bit(v.srx, 0, n, v.lsb); st = 1; end
        wr(2'd2, {8'hA5, v.tx});   // upper bits must not reach the divider (R8)
        edges = 0; capn = 0; capv = '0; irqs = 0; irq_edge = -1;
        cyc = 0; last = 0; post = 0; ivbad = 0; prev = sck;
        while (cyc < 3000 && !(edges == 2*n && post >= 6)) begin
            @(negedge clk);
            cyc++;
            if (irq) begin irqs++; irq_edge = edges; end
            if (sck != prev) begin
                lead = (prev == v.pol);
                edges++;
                if (edges > 1 && (cyc - last) != expint) ivbad++;
                last = cyc;
                if (v.pha ? !lead : lead) begin
                    if (capn < n) capv[v.lsb ? capn : n-1-capn] = sdo;
                    capn++;
                end else if (st < n) begin
                    sdi = slot_bit(v.srx, st, n, v.lsb);
                    st++;
                end
                prev = sck;
            end
            if (edges == 2*n) post++;
        end
        chk(edges == 2*n, "R6 edge count", edges, 2*n);
        chk(capv == (v.tx & mask), "R4 R5 transmitted bits", capv, v.tx & mask);
        chk(ivbad == 0, "R2 R3 half period", ivbad, 0);
        chk(sck == v.pol, "R3 resting level", sck, v.pol);
        chk(irqs == 1, "R10 one pulse per frame", irqs, 1);
        chk(irq_edge == (v.src ? 0 : 2*n), "R10 pulse position", irq_edge, v.src ? 0 : 2*n);
        rd(2'd2, r);
        chk(r == {8'h00, v.srx & mask}, "R6 R8 received frame right aligned", r, {8'h00, v.srx & mask});
        hold = slot_bit(v.tx, n-1, n, v.lsb);
        chk(sdo == hold, "R11 last bit held", sdo, hold);
        repeat (5) @(negedge clk);
        chk(sdo == hold, "R11 last bit still held", sdo, hold);
        @(negedge clk); run_en = 1'b0;
        rd(2'd2, r);
        chk(r == {v.div, 9'b0}, "R8 divider untouched by running write", r, {v.div, 9'b0});
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (4) @(negedge clk);
        // R1 reset state
        rd(2'd0, r); chk(r == 16'h0, "R1 mode word after reset", r, 0);
        rd(2'd1, r); chk(r == 16'h0, "R1 operation word after reset", r, 0);
        rd(2'd2, r); chk(r == 16'h0, "R1 data register during reset", r, 0);
        chk({sck, sdo, irq} == 3'b000, "R1 outputs during reset", {sck, sdo, irq}, 0);
        @(negedge clk); rst_n = 1'b1;
        rd(2'd2, r); chk(r == 16'h0, "R1 data register after reset", r, 0);
        chk({sck, sdo, irq} == 3'b000, "R1 outputs after reset", {sck, sdo, irq}, 0);

        // table of frame vectors
        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R7: receive enable clear, no frame may start
        @(negedge clk); run_en = 1'b0;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h8007);
        wr(2'd2, 16'h0000);
        @(negedge clk); run_en = 1'b1;
        @(posedge clk); mon_edges = 0; mon_irqs = 0;
        wr(2'd2, 16'h00AA);
        repeat (40) @(negedge clk);
        chk(mon_edges == 0, "R7 no clock without both enables", mon_edges, 0);
        chk(mon_irqs == 0, "R7 no interrupt without both enables", mon_irqs, 0);
        @(negedge clk); run_en = 1'b0;

        // R10: buffer-empty interrupt allows back-to-back frames
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'hC007);
        wr(2'd2, 16'h0200);
        @(negedge clk); run_en = 1'b1; sdi = 1'b1;
        @(posedge clk); mon_edges = 0; mon_irqs = 0; mon_cap = '0;
        wr(2'd2, 16'h00C9);
        for (int k = 0; k < 200 && mon_irqs == 0; k++) @(negedge clk);
        wr(2'd2, 16'h0036);
        for (int k = 0; k < 400 && mon_edges < 32; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(mon_edges == 32, "R10 two queued frames", mon_edges, 32);
        chk(mon_irqs == 2, "R10 two buffer-empty pulses", mon_irqs, 2);
        chk(mon_cap == 16'hC936, "R10 queued bytes in order", mon_cap, 16'hC936);
        rd(2'd2, r); chk(r == 16'h00FF, "R10 last received byte", r, 16'h00FF);

        // R9: configuration writes ignored while running
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h0000);
        @(negedge clk); run_en = 1'b0;
        rd(2'd0, r); chk(r == 16'h0001, "R9 mode word frozen", r, 16'h0001);
        rd(2'd1, r); chk(r == 16'hC007, "R9 operation word frozen", r, 16'hC007);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule